// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a set of device interrupt lines and one non-maskable line into a single request toward a CPU. It ranks the pending lines by a fixed priority and drops any line whose priority is not above the level currently being serviced. It raises one request output. When the CPU acknowledges, it freezes the winning source and offers that source's handler vector, which it reads from a small table of programmable registers.

The CPU takes the vector with a read strobe. That read saves the running level on an internal stack and raises the current level to the winner's level, so a handler can only be pre-empted by a more urgent source. A completion strobe pops the stack and restores the level that was running before. Nesting is bounded by the stack depth. If the CPU does not read the vector within a fixed window after acknowledging, the controller abandons the grant, flags a bus error and leaves the current level untouched.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `vec_valid` and `bus_err` are 0, `cur_rank` equals N_SRC+1 (idle), and vector table entry k holds VEC_BASE + 4*k for k = 0..N_SRC. Entry N_SRC belongs to the non-maskable line.
- R2: Levels are encoded as follows: rank 0 is the non-maskable line, rank i+1 is source i, and N_SRC+1 means idle. A lower rank is more urgent. Among the eligible lines the lowest index wins, and `vec_src` carries that index.
- R3: Source i is eligible only when i+1 < `cur_rank`. `irq_req` is 1 exactly when some line is eligible, no grant is open and the level stack is not full.
- R4: The non-maskable line is eligible at every level. It beats all sources, reports `vec_nmi`=1 and `vec_src`=0, and uses table entry N_SRC.
- R5: `ack` sampled while `irq_req` is 1 opens a grant. From the next cycle `vec_valid` is 1 and `vec_data`/`vec_src`/`vec_nmi` show the frozen winner, while `irq_req` stays 0. `ack` sampled while `irq_req` is 0 is ignored.
- R6: `vec_rd` sampled during a grant pushes the running level, sets `cur_rank` to the granted rank and closes the grant on the next cycle.
- R7: A grant with no `vec_rd` for TMO_CYC cycles closes. `bus_err` is then 1 for exactly one cycle and `cur_rank` keeps its value.
- R8: `eoi` restores the level saved by the latest vector read. It is ignored when nothing is saved and while a grant is open.
- R9: Up to DEPTH levels nest. With DEPTH levels saved, `irq_req` stays 0 even for the non-maskable line.
- R10: `cfg_we` writes `cfg_data` into entry `cfg_idx` when `cfg_idx` is at most N_SRC. Higher indexes change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Device request lines, bit i = source i |
| nmi_in | input | 1 | Non-maskable request line |
| ack | input | 1 | CPU acknowledge |
| vec_rd | input | 1 | CPU reads the offered vector |
| eoi | input | 1 | Completion strobe, restores previous level |
| cfg_we | input | 1 | Vector table write enable |
| cfg_idx | input | $clog2(N_SRC+1) | Vector table entry to write |
| cfg_data | input | VEC_W | Vector value to write |
| irq_req | output | 1 | Request to CPU |
| vec_valid | output | 1 | Grant open, vector offered |
| vec_data | output | VEC_W | Handler vector of granted source |
| vec_src | output | $clog2(N_SRC) | Granted source index |
| vec_nmi | output | 1 | Granted line is the non-maskable one |
| bus_err | output | 1 | Vector read timed out |
| cur_rank | output | $clog2(N_SRC+2) | Level currently being serviced |

## Verification
The bench builds the block with eight sources, a four-entry level stack, a six-cycle vector window and 16-bit vectors. Four nested grants are therefore enough to fill the stack and show the non-maskable line being held off. A short window lets the timeout path be reached with an exact cycle count. With eight sources the configuration index has spare codes beyond the non-maskable entry, so writes to those codes can be checked against the real entries they could alias onto.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_GRANT = 1'b1
    } hs_state_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // rank 0 is always reserved for the unmaskable line
    localparam int unsigned NMI_RANK = 0;

    function automatic int unsigned idle_rank(input int unsigned n_src);
        return n_src + 1;
    endfunction

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_vec_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned RANK_W = $clog2(N_SRC + 2)
) (
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              nmi_in,
    input  logic [RANK_W-1:0] cur_rank,
    output logic              any_elig,
    output logic [RANK_W-1:0] win_rank
);
    localparam int unsigned N_RANK = N_SRC + 1;

    logic [N_RANK-1:0] elig;

    assign elig[NMI_RANK] = nmi_in;

    generate
        for (genvar r = 1; r < N_RANK; r++) begin : g_elig
            localparam logic [RANK_W-1:0] RK = RANK_W'(r);
            assign elig[r] = irq_in[r-1] && (RK < cur_rank);
        end
    endgenerate

    always_comb begin
        win_rank = '0;
        for (int r = N_RANK - 1; r >= 0; r--) begin
            if (elig[r]) win_rank = RANK_W'(r);
        end
    end

    assign any_elig = |elig;

    always_comb begin
        if (any_elig) begin
            a_r2_winner_eligible: assert (elig[win_rank]);
        end
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int unsigned        N_SRC    = 8,
    parameter int unsigned        VEC_W    = 32,
    parameter logic [VEC_W-1:0]   VEC_BASE = '0,
    parameter int unsigned        IDX_W    = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_data
);
    localparam int unsigned N_ENT = N_SRC + 1;

    logic [VEC_W-1:0] ent [N_ENT];

    generate
        for (genvar k = 0; k < N_ENT; k++) begin : g_ent
            localparam logic [IDX_W-1:0] KI = IDX_W'(k);
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[k] <= VEC_BASE + VEC_W'(4 * k);
                end else if (wr_en && wr_idx == KI) begin
                    ent[k] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = ent[k];
        end
    end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_vec_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned RANK_W = $clog2(N_SRC + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [RANK_W-1:0] new_rank,
    output logic [RANK_W-1:0] cur_rank,
    output logic              full,
    output logic              empty
);
    localparam int unsigned SP_W  = $clog2(DEPTH + 1);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [RANK_W-1:0] IDLE = RANK_W'(idle_rank(N_SRC));

    logic [RANK_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    assign wr_ptr = PTR_W'(sp);
    assign rd_ptr = PTR_W'(sp - SP_W'(1));
    assign full   = (sp == SP_W'(DEPTH));
    assign empty  = (sp == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp       <= '0;
            cur_rank <= IDLE;
            for (int i = 0; i < DEPTH; i++) mem[i] <= IDLE;
        end else begin
            case (op)
                STK_PUSH: if (!full) begin
                    mem[wr_ptr] <= cur_rank;
                    cur_rank    <= new_rank;
                    sp          <= sp + SP_W'(1);
                end
                STK_POP: if (!empty) begin
                    cur_rank <= mem[rd_ptr];
                    sp       <= sp - SP_W'(1);
                end
                default: ;
            endcase
        end
    end

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(DEPTH));

    a_r6_push_raises: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH && !full) |=> (cur_rank <= $past(cur_rank)));

    a_r8_pop_lowers: assert property (@(posedge clk) disable iff (rst)
        (op == STK_POP && !empty) |=> (cur_rank >= $past(cur_rank)));

    a_r8_empty_idle: assert property (@(posedge clk) disable iff (rst)
        empty |-> (cur_rank == IDLE));

endmodule

// File: rtl/irq_hs_fsm.sv
module irq_hs_fsm
    import irq_vec_pkg::*;
#(
    parameter int unsigned RANK_W  = 4,
    parameter int unsigned TMO_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_elig,
    input  logic              stk_full,
    input  logic [RANK_W-1:0] win_rank,
    input  logic              ack,
    input  logic              vec_rd,
    output logic              irq_req,
    output logic              granted,
    output logic [RANK_W-1:0] g_rank,
    output logic              push,
    output logic              bus_err
);
    localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    hs_state_e        st;
    logic [CNT_W-1:0] wait_cnt;
    logic             expire;

    assign granted = (st == HS_GRANT);
    assign irq_req = (st == HS_IDLE) && any_elig && !stk_full;
    assign push    = granted && vec_rd;
    assign expire  = granted && !vec_rd && (wait_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= HS_IDLE;
            g_rank   <= '0;
            wait_cnt <= '0;
            bus_err  <= 1'b0;
        end else begin
            bus_err <= expire;
            case (st)
                HS_IDLE: if (ack && irq_req) begin
                    st       <= HS_GRANT;
                    g_rank   <= win_rank;
                    wait_cnt <= '0;
                end
                HS_GRANT: begin
                    if (vec_rd || expire) st <= HS_IDLE;
                    else                  wait_cnt <= wait_cnt + CNT_W'(1);
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    a_r5_grant_from_req: assert property (@(posedge clk) disable iff (rst)
        (st == HS_IDLE && !(ack && irq_req)) |=> (st == HS_IDLE));

    a_r5_rank_frozen: assert property (@(posedge clk) disable iff (rst)
        (granted && $past(granted)) |-> $stable(g_rank));

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> !bus_err);

    a_r7_err_closes: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (st == HS_IDLE));

    a_r7_window: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= LAST);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned      N_SRC    = 8,
    parameter int unsigned      DEPTH    = 4,
    parameter int unsigned      TMO_CYC  = 16,
    parameter int unsigned      VEC_W    = 32,
    parameter logic [VEC_W-1:0] VEC_BASE = '0,
    localparam int unsigned     SRC_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned     IDX_W    = $clog2(N_SRC + 1),
    localparam int unsigned     RANK_W   = $clog2(N_SRC + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              nmi_in,
    input  logic              ack,
    input  logic              vec_rd,
    input  logic              eoi,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [VEC_W-1:0]  cfg_data,
    output logic              irq_req,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_data,
    output logic [SRC_W-1:0]  vec_src,
    output logic              vec_nmi,
    output logic              bus_err,
    output logic [RANK_W-1:0] cur_rank
);
    logic              any_elig, stk_full, stk_empty, granted, push;
    logic [RANK_W-1:0] win_rank, g_rank;
    logic [IDX_W-1:0]  tbl_idx;
    stk_op_e           op;

    irq_prio_sel #(.N_SRC(N_SRC), .RANK_W(RANK_W)) u_sel (
        .irq_in   (irq_in),
        .nmi_in   (nmi_in),
        .cur_rank (cur_rank),
        .any_elig (any_elig),
        .win_rank (win_rank)
    );

    irq_hs_fsm #(.RANK_W(RANK_W), .TMO_CYC(TMO_CYC)) u_hs (
        .clk      (clk),
        .rst      (rst),
        .any_elig (any_elig),
        .stk_full (stk_full),
        .win_rank (win_rank),
        .ack      (ack),
        .vec_rd   (vec_rd),
        .irq_req  (irq_req),
        .granted  (granted),
        .g_rank   (g_rank),
        .push     (push),
        .bus_err  (bus_err)
    );

    always_comb begin
        if (push)                           op = STK_PUSH;
        else if (eoi && !granted && !stk_empty) op = STK_POP;
        else                                op = STK_HOLD;
    end

    irq_lvl_stack #(.N_SRC(N_SRC), .DEPTH(DEPTH), .RANK_W(RANK_W)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .new_rank (g_rank),
        .cur_rank (cur_rank),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    // rank 0 maps to the last table entry, rank r to source r-1
    assign vec_nmi = (g_rank == RANK_W'(NMI_RANK));
    assign tbl_idx = vec_nmi ? IDX_W'(N_SRC) : IDX_W'(g_rank - RANK_W'(1));
    assign vec_src = vec_nmi ? '0 : SRC_W'(g_rank - RANK_W'(1));

    irq_vec_table #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .rd_idx  (tbl_idx),
        .rd_data (vec_data)
    );

    assign vec_valid = granted;

    a_r5_valid_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> $past(ack && irq_req));

    a_r5_no_req_in_grant: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !irq_req);

    a_r6_read_sets_rank: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_rd) |=> (!vec_valid && cur_rank == $past(g_rank)));

    a_r8_eoi_blocked_in_grant: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_rd) |=> $stable(cur_rank));

    a_r4_nmi_unmasked: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !vec_valid && !stk_full) |-> irq_req);

endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
    localparam int unsigned N   = 8;
    localparam int unsigned DEP = 4;
    localparam int unsigned TMO = 6;
    localparam int unsigned VW  = 16;
    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [3:0]  IDLE_RK = 4'd9;

    logic clk = 1'b0, rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic nmi_in = 0, ack = 0, vec_rd = 0, eoi = 0, cfg_we = 0;
    logic [3:0] cfg_idx = '0;
    logic [VW-1:0] cfg_data = '0;
    logic irq_req, vec_valid, vec_nmi, bus_err;
    logic [VW-1:0] vec_data;
    logic [2:0] vec_src;
    logic [3:0] cur_rank;

    int checks = 0, errs = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl #(.N_SRC(N), .DEPTH(DEP), .TMO_CYC(TMO), .VEC_W(VW), .VEC_BASE(BASE)) u_irq_vec_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in), .ack(ack),
        .vec_rd(vec_rd), .eoi(eoi), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .irq_req(irq_req), .vec_valid(vec_valid),
        .vec_data(vec_data), .vec_src(vec_src), .vec_nmi(vec_nmi),
        .bus_err(bus_err), .cur_rank(cur_rank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] dflt_vec(input int idx);
        return BASE + 16'(4 * idx);
    endfunction

    // idx 8 means the unmaskable line
    task automatic serve(input logic [N-1:0] lines, input logic n, input int idx,
                         input logic [15:0] exp_vec, input string tag);
        irq_in = lines; nmi_in = n; #1;
        chk({tag, " R3 irq_req"}, irq_req, 1);
        ack = 1; tick; ack = 0;
        chk({tag, " R5 vec_valid"}, vec_valid, 1);
        chk({tag, " R5 irq_req low in grant"}, irq_req, 0);
        chk({tag, " R2 vec_data"}, vec_data, exp_vec);
        chk({tag, " R2 vec_src"}, vec_src, (idx == 8) ? 0 : idx);
        chk({tag, " R4 vec_nmi"}, vec_nmi, (idx == 8));
        vec_rd = 1; tick; vec_rd = 0;
        chk({tag, " R6 closed"}, vec_valid, 0);
        chk({tag, " R6 cur_rank"}, cur_rank, (idx == 8) ? 0 : idx + 1);
        irq_in = '0; nmi_in = 0;
    endtask

    task automatic pulse_eoi(input logic [3:0] exp_rk, input string tag);
        eoi = 1; tick; eoi = 0;
        chk({tag, " R8 cur_rank"}, cur_rank, exp_rk);
    endtask

    // {irq lines, nmi, expected winner index (8 = unmaskable)}
    localparam logic [12:0] PAT [6] = '{
        {8'b0000_0001, 1'b0, 4'd0},
        {8'b1000_0000, 1'b0, 4'd7},
        {8'b1010_0100, 1'b0, 4'd2},
        {8'b1111_0000, 1'b0, 4'd4},
        {8'b1111_1111, 1'b1, 4'd8},
        {8'b0110_0000, 1'b0, 4'd5}
    };

    initial begin
        #(200000 * 20);
        errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) tick;
        rst = 0;
        tick;
        // R1 reset state
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 bus_err", bus_err, 0);
        chk("R1 cur_rank", cur_rank, IDLE_RK);
        chk("R1 irq_req idle", irq_req, 0);

        // R2 table walk
        for (int p = 0; p < 6; p++) begin
            int w;
            w = int'(PAT[p][3:0]);
            serve(PAT[p][12:5], PAT[p][4], w, dflt_vec(w), "R2 walk");
            pulse_eoi(IDLE_RK, "walk");
        end

        // R5: ack without request ignored
        ack = 1; tick; ack = 0;
        chk("R5 ack ignored", vec_valid, 0);

        // R3 masking and R4 unmaskable override
        serve(8'h20, 0, 5, dflt_vec(5), "R3 base");
        irq_in = 8'h40; #1; chk("R3 lower masked", irq_req, 0);
        irq_in = 8'h60; #1; chk("R3 equal masked", irq_req, 0);
        irq_in = 8'h08; #1; chk("R3 higher passes", irq_req, 1);
        irq_in = 8'h00; nmi_in = 1; #1; chk("R4 nmi passes", irq_req, 1);
        nmi_in = 0;

        // R8: eoi ignored during grant
        irq_in = 8'h02; #1;
        ack = 1; tick; ack = 0;
        eoi = 1; tick; eoi = 0;
        chk("R8 grant open", vec_valid, 1);
        chk("R8 eoi ignored in grant", cur_rank, 6);
        vec_rd = 1; tick; vec_rd = 0;
        chk("R6 nested rank", cur_rank, 2);
        irq_in = '0;
        pulse_eoi(6, "R8 unwind1");
        pulse_eoi(IDLE_RK, "R8 unwind2");
        pulse_eoi(IDLE_RK, "R8 empty ignored");

        // R9 nesting to full depth
        serve(8'h80, 0, 7, dflt_vec(7), "R9 l1");
        serve(8'h20, 0, 5, dflt_vec(5), "R9 l2");
        serve(8'h04, 0, 2, dflt_vec(2), "R9 l3");
        serve(8'h01, 0, 0, dflt_vec(0), "R9 l4");
        nmi_in = 1; #1; chk("R9 full blocks nmi", irq_req, 0);
        nmi_in = 0;
        pulse_eoi(3, "R9 pop1");
        pulse_eoi(6, "R9 pop2");
        pulse_eoi(8, "R9 pop3");
        pulse_eoi(IDLE_RK, "R9 pop4");

        // R7 timeout
        irq_in = 8'h10; #1;
        ack = 1; tick; ack = 0;
        for (int c = 1; c < TMO; c++) begin
            chk("R7 still open", vec_valid, 1);
            tick;
        end
        chk("R7 last open cycle", vec_valid, 1);
        chk("R7 no err yet", bus_err, 0);
        tick;
        chk("R7 closed", vec_valid, 0);
        chk("R7 bus_err", bus_err, 1);
        chk("R7 rank kept", cur_rank, IDLE_RK);
        irq_in = '0;
        tick;
        chk("R7 err one cycle", bus_err, 0);

        // R10 table writes
        cfg_we = 1; cfg_idx = 4'd3; cfg_data = 16'hBEEF; tick;
        cfg_idx = 4'd12; cfg_data = 16'h1234; tick;
        cfg_idx = 4'd15; cfg_data = 16'h4321; tick;
        cfg_we = 0;
        serve(8'h08, 0, 3, 16'hBEEF, "R10 written");
        pulse_eoi(IDLE_RK, "R10");
        serve(8'h10, 0, 4, dflt_vec(4), "R10 alias4");
        pulse_eoi(IDLE_RK, "R10");
        serve(8'h80, 0, 7, dflt_vec(7), "R10 alias7");
        pulse_eoi(IDLE_RK, "R10");
        serve(8'h00, 1, 8, dflt_vec(8), "R10 nmi entry");
        pulse_eoi(IDLE_RK, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule